// File: doc/BRIEF.md
# Event-Selectable Hardware Performance Counter Bank

This block holds a parameterised set of hardware performance counters for a small in-order core. The counters are numbered from 3 upward, up to at most 31. Each counter has its own event-select register. Software writes a code into that register, and the code decides which pipeline event makes the counter advance. The cycle event is produced inside the block. The remaining events come in as single-cycle strobes on `evt_i`. A per-counter inhibit bit freezes a counter without changing the event it is set up for.

Software reaches the counters, the select registers and the inhibit register through a plain CSR port. A write happens in any cycle where `csr_we_i` is high. A read is combinational from `csr_addr_i`. The select registers are write-any-read-legal: any value may be written, but only a supported code is stored. A counter slot beyond the configured count reads as zero and ignores writes. Likewise, a select register beyond the configured count reads as zero and ignores writes. The CSR port is a control interface with no back-pressure, so every write is taken in the cycle it is presented. `CTR_W` must not exceed `DATA_W`, and `NUM_CTR` must lie in 1..29.

Top module: `hpm_bank`

## Requirements
- R1: After reset, every counter, every event-select register and the inhibit register read as zero.
- R2: For counter N (N = 3 .. 2+NUM_CTR), the counter is read and written at address 0xB00+N. Its event select is at 0x320+N. Bit N of the inhibit register at 0x320 belongs to counter N.
- R3: A write to an event-select register whose full data value is between 0 and 6 stores that code, and the code reads back. Any other value stores 0.
- R4: Event code 0 means no event: the counter holds its value.
- R5: Event code 1 means cycles: the counter advances by one on every clock edge while it is not inhibited.
- R6: Event codes 2..6 are, in order, retired instructions, loads, stores, taken branches and multiply wait cycles. Code k uses strobe bit `evt_i[k-2]`. The counter advances by exactly one on each edge where that bit is high, and the other strobe bits have no effect on it.
- R7: While inhibit bit N is 1, counter N holds. While it is 0, counter N counts its selected event.
- R8: A CSR write to a counter in the same cycle as a qualifying event loads the written value, and the increment is dropped.
- R9: Counter and select addresses beyond the configured count read as zero. Writes to them change no implemented state. Inhibit bits outside 3..2+NUM_CTR read as zero.
- R10: A counter read returns zeros above bit CTR_W-1. A counter write keeps only the low CTR_W bits. A counter at all ones advances to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| csr_addr_i | input | ADDR_W | CSR address for reads and writes |
| csr_we_i | input | 1 | Write strobe, taken at the next edge |
| csr_wdata_i | input | DATA_W | Write data |
| csr_rdata_o | output | DATA_W | Combinational read data for `csr_addr_i` |
| evt_i | input | 5 | Event strobes; bit k-2 belongs to code k (k = 2..6) |

## Verification
The assertions assume that `evt_i`, `csr_we_i`, `csr_addr_i` and `csr_wdata_i` are known values on every clock edge after reset. They also assume that each strobe is a level sampled once per edge. The bench drives every input on the falling edge, so it never changes an input near the sampling edge. It holds the strobes at zero while it performs register writes, except in the one case where a collision between a write and a count is the point of the test. The bench runs a small configuration of three 8-bit counters, which makes wrap-around reachable in a few cycles.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  // Number of event codes beyond "none" (1 = cycles, 2..6 = strobed events).
  localparam int NUM_EVT = 6;
  localparam int SEL_W = $clog2(NUM_EVT + 1);

  // Counter numbering and CSR placement.
  localparam int FIRST_IDX = 3;
  localparam int LAST_IDX = 31;
  localparam int INH_ADDR = 'h320;
  localparam int SEL_BASE = 'h320;
  localparam int CNT_BASE = 'hB00;

  typedef enum logic [SEL_W-1:0] {
    EV_NONE    = 3'd0,
    EV_CYCLE   = 3'd1,
    EV_RETIRE  = 3'd2,
    EV_LOAD    = 3'd3,
    EV_STORE   = 3'd4,
    EV_BRANCH  = 3'd5,
    EV_MULWAIT = 3'd6
  } evt_code_e;
endpackage

// File: rtl/hpm_sel_reg.sv
module hpm_sel_reg
  import hpm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [SEL_W-1:0]  sel_o
);
  // The whole data word is compared, so a stray upper bit makes the write illegal.
  logic legal;
  assign legal = (wdata_i <= DATA_W'(NUM_EVT));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sel_o <= EV_NONE;
    end else if (we_i) begin
      sel_o <= legal ? wdata_i[SEL_W-1:0] : EV_NONE;
    end
  end
endmodule

// File: rtl/hpm_evt_pick.sv
module hpm_evt_pick
  import hpm_pkg::*;
(
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-2:0] evt_i,
  output logic               hit_o
);
  // Code 0 never fires, code 1 always fires, codes 2.. map onto the strobe bus.
  logic [NUM_EVT:0] src;
  assign src   = {evt_i, 1'b1, 1'b0};
  assign hit_o = src[sel_i];
endmodule

// File: rtl/hpm_counter.sv
module hpm_counter #(
  parameter int CTR_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTR_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [CTR_W-1:0] cnt_o
);
  // A software write takes precedence; the concurrent increment is lost.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (we_i) begin
      cnt_o <= wdata_i;
    end else if (inc_i) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/hpm_bank.sv
module hpm_bank
  import hpm_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  csr_addr_i,
  input  logic               csr_we_i,
  input  logic [DATA_W-1:0]  csr_wdata_i,
  output logic [DATA_W-1:0]  csr_rdata_o,
  input  logic [NUM_EVT-2:0] evt_i
);
  localparam int LAST_IMPL = FIRST_IDX + NUM_CTR - 1;

  logic [NUM_CTR-1:0]            inh_q;
  logic [NUM_CTR-1:0][SEL_W-1:0] sel_q;
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q;
  logic [NUM_CTR-1:0]            hit;
  logic [NUM_CTR-1:0]            inc;

  // Inhibit register: only bits of implemented counters are kept.
  logic inh_we;
  assign inh_we = csr_we_i && (csr_addr_i == ADDR_W'(INH_ADDR));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      inh_q <= '0;
    end else if (inh_we) begin
      inh_q <= csr_wdata_i[FIRST_IDX +: NUM_CTR];
    end
  end

  // One slice per implemented counter.
  for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
    localparam int N = FIRST_IDX + g;
    logic sel_we;
    logic cnt_we;
    assign sel_we = csr_we_i && (csr_addr_i == ADDR_W'(SEL_BASE + N));
    assign cnt_we = csr_we_i && (csr_addr_i == ADDR_W'(CNT_BASE + N));

    hpm_sel_reg #(.DATA_W(DATA_W)) u_sel (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (sel_we),
      .wdata_i(csr_wdata_i),
      .sel_o  (sel_q[g])
    );

    hpm_evt_pick u_pick (
      .sel_i(sel_q[g]),
      .evt_i(evt_i),
      .hit_o(hit[g])
    );

    assign inc[g] = hit[g] & ~inh_q[g];

    hpm_counter #(.CTR_W(CTR_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cnt_we),
      .wdata_i(csr_wdata_i[CTR_W-1:0]),
      .inc_i  (inc[g]),
      .cnt_o  (cnt_q[g])
    );
  end

  // Read mux: unmatched addresses, including unimplemented slots, return zero.
  always_comb begin
    csr_rdata_o = '0;
    if (csr_addr_i == ADDR_W'(INH_ADDR)) begin
      csr_rdata_o[FIRST_IDX +: NUM_CTR] = inh_q;
    end
    for (int k = 0; k < NUM_CTR; k++) begin
      if (csr_addr_i == ADDR_W'(SEL_BASE + FIRST_IDX + k)) begin
        csr_rdata_o[SEL_W-1:0] = sel_q[k];
      end
      if (csr_addr_i == ADDR_W'(CNT_BASE + FIRST_IDX + k)) begin
        csr_rdata_o[CTR_W-1:0] = cnt_q[k];
      end
    end
  end

  // Upper bound on counter numbering; referenced so the limit is visible here.
  if (LAST_IMPL > LAST_IDX) begin : g_bad_count
    logic unused_over;
    assign unused_over = 1'b0;
  end
endmodule

// File: rtl/hpm_bank_chk.sv
module hpm_bank_chk
  import hpm_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 48,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 12
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [ADDR_W-1:0]             csr_addr_i,
  input logic                          csr_we_i,
  input logic [CTR_W-1:0]              csr_wdata_lo,
  input logic [DATA_W-1:0]             csr_rdata_o,
  input logic [NUM_EVT-2:0]            evt_i,
  input logic [NUM_CTR-1:0]            inh_q,
  input logic [NUM_CTR-1:0][SEL_W-1:0] sel_q,
  input logic [NUM_CTR-1:0][CTR_W-1:0] cnt_q
);
  localparam int FIRST_UNUSED = FIRST_IDX + NUM_CTR;

  logic unimpl_addr;
  always_comb begin
    unimpl_addr = 1'b0;
    if (int'(csr_addr_i) >= CNT_BASE + FIRST_UNUSED && int'(csr_addr_i) <= CNT_BASE + LAST_IDX)
      unimpl_addr = 1'b1;
    if (int'(csr_addr_i) >= SEL_BASE + FIRST_UNUSED && int'(csr_addr_i) <= SEL_BASE + LAST_IDX)
      unimpl_addr = 1'b1;
  end

  // R9: unimplemented slots read as zero.
  p_unimpl_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_addr |-> (csr_rdata_o == '0));

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_chk
    logic wr_cnt;
    logic strobe;
    assign wr_cnt = csr_we_i && (csr_addr_i == ADDR_W'(CNT_BASE + FIRST_IDX + g));
    always_comb begin
      strobe = 1'b0;
      for (int e = 2; e <= NUM_EVT; e++) begin
        if (int'(sel_q[g]) == e) strobe = evt_i[e-2];
      end
    end

    p_sel_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(sel_q[g]) <= NUM_EVT);

    p_hold_none_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_q[g] == '0 && !wr_cnt) |=> $stable(cnt_q[g]));

    p_cycle_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(sel_q[g]) == 1 && !inh_q[g] && !wr_cnt)
        |=> (cnt_q[g] == CTR_W'($past(cnt_q[g]) + 1'b1)));

    p_strobe_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe && !inh_q[g] && !wr_cnt)
        |=> (cnt_q[g] == CTR_W'($past(cnt_q[g]) + 1'b1)));

    p_strobe_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(sel_q[g]) >= 2 && !strobe && !wr_cnt) |=> $stable(cnt_q[g]));

    p_inhibit_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inh_q[g] && !wr_cnt) |=> $stable(cnt_q[g]));

    p_write_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cnt |=> (cnt_q[g] == $past(csr_wdata_lo)));
  end

  if (CTR_W < DATA_W) begin : g_upper
    logic cnt_addr;
    assign cnt_addr = int'(csr_addr_i) >= CNT_BASE + FIRST_IDX &&
                      int'(csr_addr_i) <  CNT_BASE + FIRST_UNUSED;
    p_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_addr |-> (csr_rdata_o[DATA_W-1:CTR_W] == '0));
  end
endmodule

bind hpm_bank hpm_bank_chk #(
  .NUM_CTR(NUM_CTR),
  .CTR_W  (CTR_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_addr_i  (csr_addr_i),
  .csr_we_i    (csr_we_i),
  .csr_wdata_lo(csr_wdata_i[CTR_W-1:0]),
  .csr_rdata_o (csr_rdata_o),
  .evt_i       (evt_i),
  .inh_q       (inh_q),
  .sel_q       (sel_q),
  .cnt_q       (cnt_q)
);

// File: tb/hpm_bank_tb_top.sv
`timescale 1ns/1ps
module hpm_bank_tb_top;
  localparam int NC = 3;
  localparam int CW = 8;
  localparam int DW = 64;
  localparam int AW = 12;
  localparam int SEL = 'h320;
  localparam int CNT = 'hB00;
  localparam int INH = 'h320;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          we;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [4:0]    evt;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hpm_bank #(.NUM_CTR(NC), .CTR_W(CW), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .csr_addr_i (addr),
    .csr_we_i   (we),
    .csr_wdata_i(wdata),
    .csr_rdata_o(rdata),
    .evt_i      (evt)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input int a, input logic [DW-1:0] d);
    addr = AW'(a); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // Samples before the next rising edge, then advances one cycle.
  task automatic rd(input int a, output logic [DW-1:0] d);
    addr = AW'(a);
    #1;
    d = rdata;
    @(negedge clk);
  endtask

  function automatic logic [4:0] pat(input int c, input int seed);
    return 5'((c * 7 + seed * 3 + (c >> 2)) ^ (c * c));
  endfunction

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] v0;
    logic [DW-1:0] bad [6];
    int exp;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int k = 0; k < NC; k++) begin
      rd(CNT + 3 + k, v); check("R1 counter", v, '0);
      rd(SEL + 3 + k, v); check("R1 select", v, '0);
    end
    rd(INH, v); check("R1 inhibit", v, '0);

    // R2 / R9: inhibit bit placement
    wr(INH, '1);
    rd(INH, v); check("R2 R9 inhibit bits", v, 64'h38);
    wr(INH, '0);

    // R4..R7 sweep: every counter, every code, inhibited or not
    for (int k = 0; k < NC; k++) begin
      for (int code = 0; code <= 6; code++) begin
        for (int ih = 0; ih < 2; ih++) begin
          wr(INH, ih != 0 ? (64'd1 << (3 + k)) : 64'd0);
          wr(SEL + 3 + k, DW'(code));
          rd(SEL + 3 + k, v); check("R2 R3 select readback", v, DW'(code));
          wr(CNT + 3 + k, '0);
          exp = 0;
          for (int c = 0; c < 20; c++) begin
            logic [4:0] p;
            p = pat(c, k * 14 + code * 2 + ih);
            evt = p;
            if (ih == 0) begin
              if (code == 1) exp++;
              else if (code >= 2 && p[code-2]) exp++;
            end
            @(negedge clk);
          end
          evt = '0;
          rd(CNT + 3 + k, v);
          if (ih != 0) check("R7 inhibited count", v, DW'(exp & 'hFF));
          else if (code == 0) check("R4 no-event count", v, DW'(exp & 'hFF));
          else if (code == 1) check("R5 cycle count", v, DW'(exp & 'hFF));
          else check("R6 strobe count", v, DW'(exp & 'hFF));
        end
      end
    end
    wr(INH, '0);

    // R3: illegal select values store zero
    bad[0] = 64'd7; bad[1] = 64'd8; bad[2] = 64'hFF;
    bad[3] = 64'h1_0000_0002; bad[4] = 64'h8000_0000_0000_0001; bad[5] = '1;
    for (int i = 0; i < 6; i++) begin
      wr(SEL + 3, 64'd5);
      wr(SEL + 3, bad[i]);
      rd(SEL + 3, v); check("R3 illegal select", v, '0);
    end

    // R8 / R10: write beats a cycle increment; upper data bits dropped
    wr(SEL + 4, 64'd1);
    wr(CNT + 4, 64'hABCD_0000_0000_0040);
    rd(CNT + 4, v); check("R8 write wins", v, 64'h40);
    rd(CNT + 4, v); check("R8 counting resumes", v, 64'h41);

    // R10: wrap-around
    wr(CNT + 4, 64'hFE);
    rd(CNT + 4, v); check("R10 before wrap", v, 64'hFE);
    rd(CNT + 4, v); check("R10 all ones", v, 64'hFF);
    rd(CNT + 4, v); check("R10 wrapped", v, 64'h00);

    // R9: unimplemented slots
    wr(SEL + 3, '0);
    rd(CNT + 3, v0);
    wr(CNT + 6, 64'h55);
    wr(SEL + 6, 64'd3);
    wr(SEL + 31, 64'd1);
    rd(CNT + 6, v); check("R9 counter 6 reads zero", v, '0);
    rd(SEL + 6, v); check("R9 select 6 reads zero", v, '0);
    rd(CNT + 31, v); check("R9 counter 31 reads zero", v, '0);
    rd(SEL + 31, v); check("R9 select 31 reads zero", v, '0);
    rd(CNT + 3, v); check("R9 implemented counter untouched", v, v0);
    wr(INH, 64'h7);
    rd(INH, v); check("R9 low inhibit bits", v, '0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule